// File: doc/BRIEF.md
# Multi-Mode Add-Operand Fetch Unit

This block carries out one accumulate instruction at a time: the destination register gets the source operand added to it. What changes from one instruction to the next is where that operand comes from. A 4-bit mode code chooses among ten ways of forming the operand. Two modes take it directly from the register file or from the instruction. The other eight form an effective address and read the operand from a single-port word memory. The memory side uses a request/ready handshake. The block holds a 16-entry, 32-bit register file. It sign-extends a 16-bit constant, and it scales the index by an element size of 1, 2, 4 or 8 bytes, which is encoded as a shift amount.

A sequencer accepts `start` only when the unit is idle. It then issues zero, one or two memory reads. After the reads it writes back the sum in one cycle, together with a base-register step when the mode calls for one. In the cycle after the write-back it pulses `done`. A combinational debug port reads any register.

Top module: `opnd_fetch_unit`

## Requirements
- R1: After reset all 16 registers read 0, and `busy`, `done` and `mem_req` are low.
- R2: Mode 0 (register) adds R[src] to R[dst] and makes no memory request. `done` goes high exactly 2 cycles after the edge that samples `start`, and it stays high for one cycle only.
- R3: Mode 1 (constant) sign-extends `imm` from bit 15 and adds it to R[dst]. It makes no memory request and has the same 2-cycle timing as R2.
- R4: Mode 2 (offset) reads at sext(imm) + R[base]. For example, base 150 with offset 100 reads address 250.
- R5: Mode 3 (through-register) reads at R[base]. Mode 4 (two-register sum) reads at R[base] + R[src].
- R6: Mode 5 (fixed address) reads at sext(imm).
- R7: Mode 6 (double pointer) makes two reads. The first is at R[base]. The second is at the word returned by the first, and the word returned by the second read is the operand.
- R8: Mode 7 (post-step) reads at the old R[base] and then writes R[base] + 2^esz back to R[base].
- R9: Mode 8 (pre-step) reads at R[base] − 2^esz and also writes that value to R[base].
- R10: Mode 9 (scaled) reads at sext(imm) + R[base] + (R[src] << esz), where esz 0..3 means element size 1, 2, 4 or 8.
- R11: A read completes only on a cycle where `mem_ready` is high. Until then `mem_req` stays high and `mem_addr` stays fixed. Each read takes (ready wait + 1) cycles, and `done` comes 2 cycles after the last read is accepted.
- R12: When dst equals base in mode 7 or 8, the destination gets the sum and the base step is lost.
- R13: Mode codes 10..15 leave every register unchanged and make no memory request, but still give `done` 2 cycles after start.
- R14: A `start` while `busy` is high is ignored, and the instruction in flight completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only while idle) |
| mode | input | 4 | Operand mode code, 0..9 valid |
| dst | input | 4 | Destination register index |
| base | input | 4 | Base register index |
| src | input | 4 | Source/index register index |
| imm | input | 16 | Constant, offset or absolute address (signed) |
| esz | input | 2 | log2 of element size |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Read address |
| mem_rdata | input | 32 | Read data, valid when mem_ready |
| mem_ready | input | 1 | Read accepted this cycle |
| dbg_sel | input | 4 | Register to observe |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The bench counts falling edges from the edge that samples `start` up to the one where `done` is seen. A register or constant instruction, or a reserved code, must show `done` at count 2. Each memory read adds its ready wait plus one cycle, so a zero-wait single read gives 3 and a one-wait double read gives 6. The bench memory raises `mem_ready` after a programmable number of waiting cycles, so it knows the exact count it expects, and it logs the address of every accepted read. Register values are read through the debug port only after `done` has been seen. One falling edge later the bench checks that `done` has dropped again.

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int IW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [3:0]              mode,
  input  logic [$clog2(NREG)-1:0] dst,
  input  logic [$clog2(NREG)-1:0] base,
  input  logic [$clog2(NREG)-1:0] src,
  input  logic [IW-1:0]           imm,
  input  logic [1:0]              esz,
  output logic                    busy,
  output logic                    done,
  output logic                    mem_req,
  output logic [DW-1:0]           mem_addr,
  input  logic [DW-1:0]           mem_rdata,
  input  logic                    mem_ready,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [DW-1:0]           dbg_data
);
  localparam int RW = $clog2(NREG);

  localparam logic [3:0] M_REG  = 4'd0;
  localparam logic [3:0] M_IMM  = 4'd1;
  localparam logic [3:0] M_DISP = 4'd2;
  localparam logic [3:0] M_RIND = 4'd3;
  localparam logic [3:0] M_IDX  = 4'd4;
  localparam logic [3:0] M_ABS  = 4'd5;
  localparam logic [3:0] M_MIND = 4'd6;
  localparam logic [3:0] M_AINC = 4'd7;
  localparam logic [3:0] M_ADEC = 4'd8;
  localparam logic [3:0] M_SCL  = 4'd9;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_WB, S_FIN} state_t;
  state_t state;

  logic [DW-1:0] regs [NREG];
  logic [3:0]    mode_q;
  logic [RW-1:0] dst_q, base_q, src_q;
  logic [IW-1:0] imm_q;
  logic [1:0]    esz_q;
  logic [DW-1:0] ptr_q, opnd_q;

  logic [DW-1:0] sx, dsz, basev, idxv, ea, operand, sum, stepped;
  logic          uses_mem, valid_op, steps;

  assign sx       = {{(DW-IW){imm_q[IW-1]}}, imm_q};
  assign dsz      = DW'(1) << esz_q;
  assign basev    = regs[base_q];
  assign idxv     = regs[src_q];
  assign uses_mem = (mode_q >= M_DISP) && (mode_q <= M_SCL);
  assign valid_op = mode_q <= M_SCL;
  assign steps    = (mode_q == M_AINC) || (mode_q == M_ADEC);
  assign stepped  = (mode_q == M_AINC) ? basev + dsz : basev - dsz;

  always_comb begin
    case (mode_q)
      M_DISP:  ea = sx + basev;
      M_IDX:   ea = basev + idxv;
      M_ABS:   ea = sx;
      M_ADEC:  ea = basev - dsz;
      M_SCL:   ea = sx + basev + (idxv << esz_q);
      default: ea = basev;
    endcase
  end

  always_comb begin
    case (mode_q)
      M_REG:   operand = idxv;
      M_IMM:   operand = sx;
      default: operand = opnd_q;
    endcase
  end

  assign sum      = regs[dst_q] + operand;
  assign busy     = state != S_IDLE;
  assign done     = state == S_FIN;
  assign mem_req  = (state == S_RD1) || (state == S_RD2);
  assign mem_addr = (state == S_RD2) ? ptr_q : ea;
  assign dbg_data = regs[dbg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= '0;
      dst_q  <= '0;
      base_q <= '0;
      src_q  <= '0;
      imm_q  <= '0;
      esz_q  <= '0;
      ptr_q  <= '0;
      opnd_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          mode_q <= mode;
          dst_q  <= dst;
          base_q <= base;
          src_q  <= src;
          imm_q  <= imm;
          esz_q  <= esz;
          state  <= (mode >= M_DISP && mode <= M_SCL) ? S_RD1 : S_WB;
        end
        S_RD1: if (mem_ready) begin
          if (mode_q == M_MIND) begin
            ptr_q <= mem_rdata;
            state <= S_RD2;
          end else begin
            opnd_q <= mem_rdata;
            state  <= S_WB;
          end
        end
        S_RD2: if (mem_ready) begin
          opnd_q <= mem_rdata;
          state  <= S_WB;
        end
        S_WB:    state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (state == S_WB && valid_op) begin
      if (steps) regs[base_q] <= stepped;
      regs[dst_q] <= sum;
    end
  end

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  a_r3_no_mem_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !uses_mem) |-> !mem_req);
  a_r14_hold_instr: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q) && $stable(dst_q) && $stable(imm_q));
  a_r7_second_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD2) |-> (mode_q == M_MIND));
  a_r11_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !(state == S_RD1 && mode_q == M_MIND)) |=> !mem_req ##1 done);
endmodule

// File: tb/opnd_fetch_unit_tb.sv
module opnd_fetch_unit_tb;
  logic clk = 0, rst_n = 0, start = 0, mem_ready = 0;
  logic [3:0] mode = 0, dst = 0, base = 0, src = 0, dbg_sel = 0;
  logic [15:0] imm = 0;
  logic [1:0] esz = 0;
  logic busy, done, mem_req;
  logic [31:0] mem_addr, mem_rdata, dbg_data;

  logic [31:0] mem [256];
  logic [31:0] regm [16];
  logic [31:0] alog [64];
  int rd_total = 0, wcnt = 0, delay = 0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  opnd_fetch_unit u_dut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .dst(dst), .base(base), .src(src), .imm(imm), .esz(esz), .busy(busy),
    .done(done), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .dbg_sel(dbg_sel), .dbg_data(dbg_data));

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(negedge clk) begin
    if (mem_req && wcnt == delay) begin mem_ready = 1; wcnt = 0; end
    else begin mem_ready = 0; if (mem_req) wcnt = wcnt + 1; end
  end

  always @(posedge clk) if (mem_req && mem_ready) begin
    alog[rd_total % 64] <= mem_addr;
    rd_total <= rd_total + 1;
  end

  function automatic logic [31:0] v(input logic [31:0] a);
    return mem[a[7:0]];
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int r = 0; r < 16; r++) begin
      dbg_sel = 4'(r);
      #1;
      chk($sformatf("%s reg%0d", tag, r), dbg_data, regm[r]);
    end
  endtask

  task automatic exec(input logic [3:0] m, input logic [3:0] d, input logic [3:0] b,
                      input logic [3:0] x, input logic [15:0] im, input logic [1:0] es,
                      input int dly, input int exp_cyc, input int exp_n,
                      input logic [31:0] a0, input logic [31:0] a1, input string tag);
    int cyc, n0;
    delay = dly;
    @(negedge clk);
    n0 = rd_total;
    mode = m; dst = d; base = b; src = x; imm = im; esz = es; start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk({tag, " done cycle"}, cyc, exp_cyc);
    chk({tag, " read count"}, rd_total - n0, exp_n);
    if (exp_n > 0) chk({tag, " addr0"}, alog[n0 % 64], a0);
    if (exp_n > 1) chk({tag, " addr1"}, alog[(n0 + 1) % 64], a1);
    @(negedge clk);
    chk({tag, " done low after pulse"}, 32'(done), 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    check_regs("R1");
  endtask

  task automatic t_imm;
    exec(1, 1, 0, 0, 16'd150, 0, 0, 2, 0, 0, 0, "R3 pos");
    regm[1] = 150;
    exec(1, 2, 0, 0, 16'hFFFC, 0, 0, 2, 0, 0, 0, "R3 neg");
    regm[2] = 32'hFFFFFFFC;
    check_regs("R3");
  endtask

  task automatic t_reg;
    exec(0, 3, 0, 1, 0, 0, 0, 2, 0, 0, 0, "R2 a");
    regm[3] = 150;
    exec(0, 2, 0, 1, 0, 0, 0, 2, 0, 0, 0, "R2 b");
    regm[2] = 146;
    check_regs("R2");
  endtask

  task automatic t_disp;
    exec(2, 4, 1, 0, 16'd100, 0, 0, 3, 1, 250, 0, "R4 pos");
    regm[4] = v(250);
    exec(2, 4, 1, 0, 16'hFFF6, 0, 2, 5, 1, 140, 0, "R4 R11 wait2");
    regm[4] = regm[4] + v(140);
    check_regs("R4");
  endtask

  task automatic t_ind;
    exec(3, 5, 1, 0, 0, 0, 0, 3, 1, 150, 0, "R5 rind");
    regm[5] = v(150);
    exec(4, 5, 1, 3, 0, 0, 0, 3, 1, 300, 0, "R5 idx");
    regm[5] = regm[5] + v(300);
    check_regs("R5");
  endtask

  task automatic t_abs;
    exec(5, 10, 0, 0, 16'h0040, 0, 0, 3, 1, 64, 0, "R6 pos");
    regm[10] = v(64);
    exec(5, 10, 0, 0, 16'h8000, 0, 0, 3, 1, 32'hFFFF8000, 0, "R6 neg");
    regm[10] = regm[10] + v(0);
    check_regs("R6");
  endtask

  task automatic t_mind;
    exec(6, 6, 1, 0, 0, 0, 1, 6, 2, 150, 200, "R7 R11");
    regm[6] = v(200);
    check_regs("R7");
  endtask

  task automatic t_ainc;
    exec(7, 11, 1, 0, 0, 2, 0, 3, 1, 150, 0, "R8");
    regm[11] = v(150);
    regm[1] = 154;
    check_regs("R8");
  endtask

  task automatic t_adec;
    exec(8, 12, 1, 0, 0, 3, 0, 3, 1, 146, 0, "R9");
    regm[12] = v(146);
    regm[1] = 146;
    check_regs("R9");
  endtask

  task automatic t_scl;
    exec(1, 7, 0, 0, 16'd3, 0, 0, 2, 0, 0, 0, "R10 setup");
    regm[7] = 3;
    exec(9, 13, 1, 7, 16'd8, 2, 0, 3, 1, 166, 0, "R10 d4");
    regm[13] = v(166);
    exec(9, 13, 1, 7, 16'd8, 0, 0, 3, 1, 157, 0, "R10 d1");
    regm[13] = regm[13] + v(157);
    check_regs("R10");
  endtask

  task automatic t_same;
    exec(1, 8, 0, 0, 16'd20, 0, 0, 2, 0, 0, 0, "R12 setup");
    exec(7, 8, 8, 0, 0, 0, 0, 3, 1, 20, 0, "R12");
    regm[8] = 20 + v(20);
    check_regs("R12");
  endtask

  task automatic t_busy;
    int n0, dones;
    delay = 3;
    @(negedge clk);
    n0 = rd_total;
    mode = 2; dst = 4; base = 1; src = 0; imm = 0; esz = 0; start = 1;
    @(negedge clk);
    start = 0;
    mode = 1; dst = 9; imm = 16'd5; start = 1;
    @(negedge clk);
    start = 0;
    dones = 0;
    for (int i = 0; i < 20; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk("R14 single done", dones, 1);
    chk("R14 read count", rd_total - n0, 1);
    chk("R14 addr", alog[n0 % 64], 146);
    regm[4] = regm[4] + v(146);
    check_regs("R14");
  endtask

  task automatic t_rsv;
    exec(12, 1, 1, 1, 16'd77, 1, 0, 2, 0, 0, 0, "R13 c12");
    exec(15, 3, 3, 3, 16'hFFFF, 3, 0, 2, 0, 0, 0, "R13 c15");
    check_regs("R13");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0001_0000 + 32'(i) * 7;
    mem[150] = 200;
    for (int i = 0; i < 16; i++) regm[i] = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_imm;
    t_reg;
    t_disp;
    t_ind;
    t_abs;
    t_mind;
    t_ainc;
    t_adec;
    t_scl;
    t_same;
    t_busy;
    t_rsv;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule